// File: doc/BRIEF.md
# Partial-Word Load Merge Unit

This block finishes the unaligned "left" and "right" partial loads of a 64-bit load/store pipe. Memory returns an aligned word (32-bit forms) or an aligned doubleword (64-bit forms), already fetched from the effective address with its low bits cleared. Those cleared bits form the byte offset k. The block shifts the fetched data into place and keeps the bytes of the old destination register that the instruction must not overwrite. It then applies the sign-extension rule of each form and presents the new 64-bit register value one cycle later, with a write-enable for the register file.

A left/right pair of the same width together assembles an unaligned value. The 32-bit forms have their own rules for the upper half of the register. The left form always sign-extends its merged word. The right form sign-extends only when it loads the whole word (k = 0), and otherwise leaves the upper 32 bits as they were. Address generation, the memory access and the register file itself sit outside the block.

Top module: `partial_load_merge`

## Requirements
- R1: `in_op` encodes 0 = 32-bit left, 1 = 32-bit right, 2 = 64-bit left, 3 = 64-bit right. Byte lanes are little-endian: byte 0 is bits 7:0 of the memory data. For the 32-bit left form with k = `in_ofs[1:0]`, result bits 31:0 equal (mem[31:0] << (24 − 8k)) OR (old[31:0] AND mask). The mask keeps the lowest 3 − k bytes of the old value.
- R2: The 32-bit left form always fills result bits 63:32 with copies of result bit 31.
- R3: For the 32-bit right form, result bits 31:0 equal (mem[31:0] >> 8k) OR (old[31:0] AND mask). The mask keeps the highest k bytes of the old value.
- R4: For the 32-bit right form with k = 0, result bits 63:32 are copies of result bit 31. With k = 1..3, result bits 63:32 equal old bits 63:32.
- R5: For the 64-bit left form with k = `in_ofs[2:0]`, the result equals (mem << (56 − 8k)) OR (old AND mask). The mask keeps the lowest 7 − k bytes of the old value. At k = 7 the result equals the memory doubleword.
- R6: For the 64-bit right form, the result equals (mem >> 8k) OR (old AND mask). The mask keeps the highest k bytes of the old value. At k = 0 the result equals the memory doubleword.
- R7: `out_we` is high exactly when `out_valid` is high and the captured destination index is nonzero. A zero index never raises `out_we`.
- R8: `out_valid` equals `in_valid` from the previous clock. `out_data` and `out_rd` belong to that same input, one cycle after it.
- R9: A synchronous active-high `rst` clears `out_valid` and `out_we` at the next clock edge, even when `in_valid` is high.
- R10: The 32-bit forms ignore `in_mem[63:32]` and `in_ofs[2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input operation is present |
| in_op | input | 2 | Operation select (see R1) |
| in_ofs | input | 3 | Low effective-address bits (byte offset) |
| in_mem | input | 64 | Aligned memory data; the 32-bit forms use bits 31:0 |
| in_old | input | 64 | Previous destination register value |
| in_rd | input | 5 | Destination register index |
| out_valid | output | 1 | Result present |
| out_we | output | 1 | Register write-enable |
| out_rd | output | 5 | Destination register index of the result |
| out_data | output | 64 | New destination register value |

## Verification
The hardest case to reach from the ports is the 32-bit right form at a nonzero offset, where the upper half must survive unchanged. It can only be told apart from a wrong sign extension when the old upper half differs from the sign of the merged word. The stimulus therefore crosses memory and register patterns whose sign bits are set and clear, and it uses an old upper half that is neither all ones nor all zeros. Every offset 0..7 is driven for every operation, and the memory upper half holds non-zero data throughout. This also shows that the 32-bit forms ignore offset bit 2 and the unused memory half. Idle gaps, a zero destination index and a reset pulse with `in_valid` high are placed inside the stream.

// File: rtl/plm_pkg.sv
package plm_pkg;

   // operation select; 32-bit forms use the low memory half
   typedef enum logic [1:0] {
      PLM_LEFT_W  = 2'd0,
      PLM_RIGHT_W = 2'd1,
      PLM_LEFT_D  = 2'd2,
      PLM_RIGHT_D = 2'd3
   } plm_op_e;

endpackage

// File: rtl/plm_lane_merge.sv
// Byte-lane merge for one access width: each lane picks either a shifted
// memory byte or keeps the old register byte.
module plm_lane_merge #(
   parameter int NB = 8,
   localparam int KW = (NB > 1) ? $clog2(NB) : 1,
   localparam int DW = 8 * NB
) (
   input  logic          is_left,
   input  logic [KW-1:0] k,
   input  logic [DW-1:0] mem,
   input  logic [DW-1:0] old,
   output logic [DW-1:0] merged
);

   generate
      if (NB < 2 || (NB & (NB - 1)) != 0) begin : g_bad_nb
         $error("plm_lane_merge: NB must be a power of two, at least 2");
      end
   endgenerate

   genvar j;
   generate
      for (j = 0; j < NB; j++) begin : g_lane
         logic [7:0]    lane_b;
         logic [KW-1:0] idx;
         int            src;
         always_comb begin
            // left: lane j gets mem byte j-(NB-1-k); right: mem byte j+k
            if (is_left) src = j + int'(k) - (NB - 1);
            else         src = j + int'(k);
            idx = src[KW-1:0];
            if (src >= 0 && src < NB) lane_b = mem[idx*8 +: 8];
            else                      lane_b = old[j*8 +: 8];
         end
         assign merged[j*8 +: 8] = lane_b;
      end
   endgenerate

endmodule

// File: rtl/plm_result_sel.sv
// Chooses between narrow and wide merge results and applies the
// upper-half rule of the 32-bit forms.
module plm_result_sel
   import plm_pkg::*;
#(
   parameter int REG_W = 64,
   localparam int HW = REG_W / 2
) (
   input  plm_op_e          op,
   input  logic             narrow_k_zero,
   input  logic [HW-1:0]    narrow,
   input  logic [REG_W-1:0] wide,
   input  logic [HW-1:0]    old_hi,
   output logic [REG_W-1:0] result
);

   always_comb begin
      unique case (op)
         PLM_LEFT_W:  result = {{HW{narrow[HW-1]}}, narrow};
         PLM_RIGHT_W: result = narrow_k_zero ? {{HW{narrow[HW-1]}}, narrow}
                                             : {old_hi, narrow};
         default:     result = wide;
      endcase
   end

endmodule

// File: rtl/partial_load_merge.sv
module partial_load_merge
   import plm_pkg::*;
#(
   parameter int REG_W  = 64,
   parameter int RIDX_W = 5,
   localparam int HW     = REG_W / 2,
   localparam int NB_W   = REG_W / 8,
   localparam int NB_N   = NB_W / 2,
   localparam int OFS_W  = $clog2(NB_W),
   localparam int NOFS_W = $clog2(NB_N)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [1:0]        in_op,
   input  logic [OFS_W-1:0]  in_ofs,
   input  logic [REG_W-1:0]  in_mem,
   input  logic [REG_W-1:0]  in_old,
   input  logic [RIDX_W-1:0] in_rd,
   output logic              out_valid,
   output logic              out_we,
   output logic [RIDX_W-1:0] out_rd,
   output logic [REG_W-1:0]  out_data
);

   generate
      if (REG_W < 32 || (REG_W & (REG_W - 1)) != 0) begin : g_bad_w
         $error("partial_load_merge: REG_W must be a power of two >= 32");
      end
      if (RIDX_W < 1) begin : g_bad_ridx
         $error("partial_load_merge: RIDX_W must be at least 1");
      end
   endgenerate

   plm_op_e           op;
   logic              is_left;
   logic [NOFS_W-1:0] k_n;
   logic [HW-1:0]     merged_n;
   logic [REG_W-1:0]  merged_w;
   logic [REG_W-1:0]  result;

   assign op      = plm_op_e'(in_op);
   assign is_left = (op == PLM_LEFT_W) || (op == PLM_LEFT_D);
   assign k_n     = in_ofs[NOFS_W-1:0];

   plm_lane_merge #(.NB(NB_N)) u_narrow (
      .is_left (is_left),
      .k       (k_n),
      .mem     (in_mem[HW-1:0]),
      .old     (in_old[HW-1:0]),
      .merged  (merged_n)
   );

   plm_lane_merge #(.NB(NB_W)) u_wide (
      .is_left (is_left),
      .k       (in_ofs),
      .mem     (in_mem),
      .old     (in_old),
      .merged  (merged_w)
   );

   plm_result_sel #(.REG_W(REG_W)) u_sel (
      .op            (op),
      .narrow_k_zero (k_n == '0),
      .narrow        (merged_n),
      .wide          (merged_w),
      .old_hi        (in_old[REG_W-1:HW]),
      .result        (result)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_we    <= 1'b0;
      end else begin
         out_valid <= in_valid;
         out_we    <= in_valid && (in_rd != '0);
      end
      if (in_valid) begin
         out_data <= result;
         out_rd   <= in_rd;
      end
   end

   // R7
   we_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
      out_we |-> (out_valid && out_rd != '0));

   // R7
   zero_rd_no_we_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_rd == '0) |=> !out_we);

   // R8
   valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   // R8
   idle_follows_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   // R2
   left_w_sext_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_op == PLM_LEFT_W) |=>
         (out_data[REG_W-1:HW] == {HW{out_data[HW-1]}}));

   // R4
   right_w_keep_hi_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_op == PLM_RIGHT_W && in_ofs[NOFS_W-1:0] != '0) |=>
         (out_data[REG_W-1:HW] == $past(in_old[REG_W-1:HW])));

   // R5
   left_d_full_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_op == PLM_LEFT_D && in_ofs == '1) |=>
         (out_data == $past(in_mem)));

   // R6
   right_d_full_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_op == PLM_RIGHT_D && in_ofs == '0) |=>
         (out_data == $past(in_mem)));

endmodule

// File: tb/partial_load_merge_test.sv
module partial_load_merge_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [1:0]  in_op = '0;
   logic [2:0]  in_ofs = '0;
   logic [63:0] in_mem = '0;
   logic [63:0] in_old = '0;
   logic [4:0]  in_rd = '0;
   logic        out_valid, out_we;
   logic [4:0]  out_rd;
   logic [63:0] out_data;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit mon_on = 1'b0;

   always #2 clk = ~clk;

   partial_load_merge uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
      .in_ofs(in_ofs), .in_mem(in_mem), .in_old(in_old), .in_rd(in_rd),
      .out_valid(out_valid), .out_we(out_we), .out_rd(out_rd),
      .out_data(out_data)
   );

   function automatic logic [63:0] model(logic [1:0] op, logic [2:0] ofs,
                                         logic [63:0] mem, logic [63:0] old);
      int k;
      logic [31:0] lo, msk;
      logic [63:0] m64;
      case (op)
         2'd0: begin
            k   = int'(ofs[1:0]);
            msk = (32'd1 << (8 * (3 - k))) - 32'd1;
            lo  = (mem[31:0] << (24 - 8 * k)) | (old[31:0] & msk);
            return {{32{lo[31]}}, lo};
         end
         2'd1: begin
            k   = int'(ofs[1:0]);
            msk = ~(32'hFFFF_FFFF >> (8 * k));
            lo  = (mem[31:0] >> (8 * k)) | (old[31:0] & msk);
            if (k == 0) return {{32{lo[31]}}, lo};
            return {old[63:32], lo};
         end
         2'd2: begin
            k   = int'(ofs);
            m64 = (64'd1 << (8 * (7 - k))) - 64'd1;
            return (mem << (56 - 8 * k)) | (old & m64);
         end
         default: begin
            k   = int'(ofs);
            m64 = ~(64'hFFFF_FFFF_FFFF_FFFF >> (8 * k));
            return (mem >> (8 * k)) | (old & m64);
         end
      endcase
   endfunction

   // cycle model of the output register
   logic        mdl_valid = 1'b0, mdl_we = 1'b0, mdl_rst = 1'b1;
   logic [4:0]  mdl_rd = '0;
   logic [63:0] mdl_data = '0;
   string       mdl_lo_tag = "R1", mdl_hi_tag = "R2";

   always @(posedge clk) begin
      cycles  <= cycles + 1;
      mon_on  <= 1'b1;
      mdl_rst <= rst;
      mdl_valid <= rst ? 1'b0 : in_valid;
      mdl_we    <= rst ? 1'b0 : (in_valid && in_rd != 5'd0);
      if (in_valid) begin
         mdl_data <= model(in_op, in_ofs, in_mem, in_old);
         mdl_rd   <= in_rd;
         case (in_op)
            2'd0: begin mdl_lo_tag <= in_ofs[2] ? "R10" : "R1"; mdl_hi_tag <= "R2"; end
            2'd1: begin mdl_lo_tag <= in_ofs[2] ? "R10" : "R3"; mdl_hi_tag <= "R4"; end
            2'd2: begin mdl_lo_tag <= "R5"; mdl_hi_tag <= "R5"; end
            default: begin mdl_lo_tag <= "R6"; mdl_hi_tag <= "R6"; end
         endcase
      end
   end

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (mon_on) begin
         chk(mdl_rst ? "R9" : "R8", "out_valid", 64'(out_valid), 64'(mdl_valid));
         chk(mdl_rst ? "R9" : "R7", "out_we", 64'(out_we), 64'(mdl_we));
         if (mdl_valid) begin
            chk("R8", "out_rd", 64'(out_rd), 64'(mdl_rd));
            chk(mdl_lo_tag, "out_data[31:0]", 64'(out_data[31:0]), 64'(mdl_data[31:0]));
            chk(mdl_hi_tag, "out_data[63:32]", 64'(out_data[63:32]), 64'(mdl_data[63:32]));
         end
      end
   end

   initial begin
      if (cycles < 0) $display("unreachable");
      wait (cycles > 20000);
      errors++;
      checks++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [63:0] mset, mclr, oset, oclr;
      int n;
      mset = 64'h8899_AABB_C1D2_E3F4;
      mclr = 64'h1122_3344_5566_7788;
      oset = 64'h5A1B_2C3D_F4E5_D6C7;
      oclr = 64'hA0E1_D2C3_0B4A_5968;
      n = 0;
      // R9: reset with valid input pending
      in_valid = 1'b1;
      in_rd    = 5'd9;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      in_valid = 1'b0;
      for (int op = 0; op < 4; op++) begin
         for (int p = 0; p < 4; p++) begin
            for (int ofs = 0; ofs < 8; ofs++) begin
               @(negedge clk);
               n++;
               in_op    = 2'(op);
               in_ofs   = 3'(ofs);
               in_mem   = p[0] ? mset : mclr;
               in_old   = p[1] ? oset : oclr;
               in_rd    = (n % 7 == 3) ? 5'd0 : 5'(n);
               in_valid = 1'b1;
               if (n % 6 == 5) begin
                  @(negedge clk);
                  in_valid = 1'b0;
                  in_mem   = ~in_mem;
               end
               if (n == 40) begin
                  // R9: mid-stream reset while valid is high
                  rst = 1'b1;
                  @(negedge clk);
                  rst = 1'b0;
               end
            end
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule